// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives the flash controller of a debug target through an external memory-access engine. One accepted command either programs a single word, erases flash in one of five modes, or runs a full erase. Each operation is a fixed sequence of steps:

- key-protected writes to the target's flash control registers;
- a trigger write;
- a switch of the target back to read mode through a control-signal word;
- a counted burst on the `tclk` output, which clocks the target's flash timing generator;
- a final write that turns flash writes off.

Programming is wrapped in a CPU halt and a CPU release, which are sent to the CPU control sequencer over their own handshake port.

Commands enter over a valid/ready port. `cmd_ready` is high only while the block is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high, and its fields are captured at that moment. A producer facing a low `cmd_ready` keeps `cmd_valid` and its fields steady until the block is idle again.

The engine port and the CPU port are driven with valid/ready as well. The block keeps `eng_valid` or `cpu_valid` high, with a steady payload, until the receiver raises ready. A write counts as complete in the cycle of its handshake. The burst rate follows from `tclk_half`, which must be held steady while a command runs. A half period of about 286 system clocks gives roughly 350 kHz from a 200 MHz clock.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `tclk`, `done`, `eng_valid` and `cpu_valid` are 0. `cmd_ready` is 1 only while idle, and it falls in the cycle after a command is taken. Fields that change after acceptance have no effect on the operation.
- R2: `cmd_op` = 0 (program) issues the following steps, in this order:
  - halt (`cpu_release` = 0);
  - memory writes 0xA540 to 0x0128, 0xA540 to 0x012A and 0xA500 to 0x012C;
  - a memory write of `cmd_data` to `cmd_addr`;
  - a control word 0x2409 (`eng_ctl` = 1, `eng_addr` = 0);
  - a burst of PROG_PULSES (default 35) pulses;
  - a write of 0xA500 to 0x0128;
  - release (`cpu_release` = 1).
- R3: `cmd_op` = 1 (erase) issues the following steps, in this order:
  - a write of the erase code to 0x0128;
  - writes of 0xA540 to 0x012A and 0xA500 to 0x012C;
  - a write of 0x55AA to `cmd_addr`;
  - control word 0x2409;
  - a burst of `cmd_pulses` pulses;
  - a write of 0xA500 to 0x0128.
- R4: The erase code comes from `cmd_erase_sel`:
  - 0 gives 0xA502 (segment);
  - 1 gives 0xA504 (main);
  - 2 gives 0xA506 (mass);
  - 3 gives 0xA50C (all main);
  - 4 gives 0xA50E (global);
  - 5 to 7 give 0xA502.
- R5: `cmd_op` = 2 (full erase) runs the erase sequence three times back to back. Each pass uses code 0xA506, address 0xFFFE and FULL_PULSES pulses.
- R6: Each burst pulse is high for H cycles and then low for H cycles, where H is `tclk_half`, or 1 when `tclk_half` is 0. `tclk` is low whenever no burst runs.
- R7: A pulse count of 0 produces no `tclk` pulse, and the sequence carries on with the next step.
- R8: While `eng_valid` or `cpu_valid` waits for ready, it stays high and its payload stays unchanged. The two valids are never high together.
- R9: `done` is a one-cycle pulse that comes only after the final step's handshake. `cmd_ready` is high in the same cycle.
- R10: `cmd_op` = 3 is accepted and completes with `done`, without any engine or CPU transaction and without pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 program, 1 erase, 2 full erase, 3 no-op |
| cmd_addr | input | 16 | Target address for program or erase |
| cmd_data | input | 16 | Word to program |
| cmd_erase_sel | input | 3 | Erase mode select |
| cmd_pulses | input | 16 | Erase burst pulse count |
| tclk_half | input | DIV_W | Burst half period in clocks, 0 treated as 1 |
| eng_valid | output | 1 | Engine request valid |
| eng_ready | input | 1 | Engine accepts request |
| eng_ctl | output | 1 | 1 control-signal word, 0 memory write |
| eng_addr | output | 16 | Write address (0 for control word) |
| eng_data | output | 16 | Write data or control word |
| cpu_valid | output | 1 | CPU control request valid |
| cpu_ready | input | 1 | CPU control sequencer accepts |
| cpu_release | output | 1 | 0 halt, 1 release |
| tclk | output | 1 | Flash timing clock burst |
| done | output | 1 | Operation complete pulse |

## Verification
The bench varies the engine and CPU ready signals at random to stretch every handshake. A design that skipped a step, advanced without ready, or altered the payload while stalled would show up as a wrong entry in the logged transaction order.

It also covers these cases, each with the failure it would expose:
- Every erase select value, including the unused ones, where a wrong code would be written to the control register.
- A zero pulse count, where a design that counted down from zero would emit 65536 pulses.
- A half period of 0, where a zero-length phase would hang or glitch.
- A full erase, where an off-by-one in the repeat count would give two or four passes.

Scrambling the command fields right after acceptance catches a design that reads the live inputs instead of its captured copy.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_FULL  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ACT_HALT    = 3'd0,
    ACT_RELEASE = 3'd1,
    ACT_MEMWR   = 3'd2,
    ACT_CTL     = 3'd3,
    ACT_BURST   = 3'd4,
    ACT_END     = 3'd5
  } act_e;

  typedef struct packed {
    act_e              act;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } step_t;

  // flash controller register addresses
  localparam logic [WORD_W-1:0] FREG_MODE  = 16'h0128;
  localparam logic [WORD_W-1:0] FREG_CLK   = 16'h012A;
  localparam logic [WORD_W-1:0] FREG_LOCK  = 16'h012C;
  // key-protected values
  localparam logic [WORD_W-1:0] KV_WRITE_ON = 16'hA540;
  localparam logic [WORD_W-1:0] KV_CLK_SRC  = 16'hA540;
  localparam logic [WORD_W-1:0] KV_UNLOCK   = 16'hA500;
  localparam logic [WORD_W-1:0] KV_MODE_OFF = 16'hA500;
  localparam logic [WORD_W-1:0] ERASE_DUMMY = 16'h55AA;
  localparam logic [WORD_W-1:0] CTL_READ    = 16'h2409;
  localparam logic [WORD_W-1:0] FULL_ADDR   = 16'hFFFE;

  function automatic logic [WORD_W-1:0] erase_code(input logic [2:0] sel);
    case (sel)
      3'd1:    return 16'hA504;
      3'd2:    return 16'hA506;
      3'd3:    return 16'hA50C;
      3'd4:    return 16'hA50E;
      default: return 16'hA502;
    endcase
  endfunction
endpackage

// File: rtl/fps_step_table.sv
module fps_step_table
  import fps_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int PROG_PULSES = 35,
  parameter int FULL_PULSES = 65535
) (
  input  op_e                   op,
  input  logic [IDX_W-1:0]      idx,
  input  logic [WORD_W-1:0]     addr,
  input  logic [WORD_W-1:0]     data,
  input  logic [2:0]            erase_sel,
  input  logic [WORD_W-1:0]     pulses,
  output step_t                 step
);
  logic [WORD_W-1:0] er_code, er_addr, er_cnt;

  always_comb begin
    er_code = (op == OP_FULL) ? erase_code(3'd2) : erase_code(erase_sel);
    er_addr = (op == OP_FULL) ? FULL_ADDR : addr;
    er_cnt  = (op == OP_FULL) ? WORD_W'(FULL_PULSES) : pulses;
  end

  always_comb begin
    step = '{act: ACT_END, addr: '0, data: '0};
    if (op == OP_PROG) begin
      case (idx)
        4'd0: step = '{ACT_HALT,    '0,        '0};
        4'd1: step = '{ACT_MEMWR,   FREG_MODE, KV_WRITE_ON};
        4'd2: step = '{ACT_MEMWR,   FREG_CLK,  KV_CLK_SRC};
        4'd3: step = '{ACT_MEMWR,   FREG_LOCK, KV_UNLOCK};
        4'd4: step = '{ACT_MEMWR,   addr,      data};
        4'd5: step = '{ACT_CTL,     '0,        CTL_READ};
        4'd6: step = '{ACT_BURST,   '0,        WORD_W'(PROG_PULSES)};
        4'd7: step = '{ACT_MEMWR,   FREG_MODE, KV_MODE_OFF};
        4'd8: step = '{ACT_RELEASE, '0,        '0};
        default: step = '{ACT_END,  '0,        '0};
      endcase
    end else if (op == OP_ERASE || op == OP_FULL) begin
      case (idx)
        4'd0: step = '{ACT_MEMWR, FREG_MODE, er_code};
        4'd1: step = '{ACT_MEMWR, FREG_CLK,  KV_CLK_SRC};
        4'd2: step = '{ACT_MEMWR, FREG_LOCK, KV_UNLOCK};
        4'd3: step = '{ACT_MEMWR, er_addr,   ERASE_DUMMY};
        4'd4: step = '{ACT_CTL,   '0,        CTL_READ};
        4'd5: step = '{ACT_BURST, '0,        er_cnt};
        4'd6: step = '{ACT_MEMWR, FREG_MODE, KV_MODE_OFF};
        default: step = '{ACT_END, '0,       '0};
      endcase
    end
  end
endmodule

// File: rtl/fps_tclk_burst.sv
module fps_tclk_burst #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [DIV_W-1:0] half,
  output logic             tclk,
  output logic             done
);
  logic [CNT_W-1:0] rem;
  logic [DIV_W-1:0] ph, hq, heff;
  logic             busy;

  always_comb heff = (half == '0) ? DIV_W'(1) : half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      ph   <= '0;
      hq   <= DIV_W'(1);
      busy <= 1'b0;
      tclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          tclk <= 1'b1;
          rem  <= count;
          hq   <= heff;
          ph   <= heff - 1'b1;
        end
      end else if (busy) begin
        if (ph != '0) begin
          ph <= ph - 1'b1;
        end else if (tclk) begin
          tclk <= 1'b0;
          ph   <= hq - 1'b1;
        end else if (rem == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem  <= rem - 1'b1;
          tclk <= 1'b1;
          ph   <= hq - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int PROG_PULSES = 35,
  parameter int FULL_PULSES = 65535,
  parameter int REPEATS     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       cmd_addr,
  input  logic [15:0]       cmd_data,
  input  logic [2:0]        cmd_erase_sel,
  input  logic [15:0]       cmd_pulses,
  input  logic [DIV_W-1:0]  tclk_half,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic              eng_ctl,
  output logic [15:0]       eng_addr,
  output logic [15:0]       eng_data,
  output logic              cpu_valid,
  input  logic              cpu_ready,
  output logic              cpu_release,
  output logic              tclk,
  output logic              done
);
  localparam int IDX_W = 4;
  localparam int REP_W = $clog2(REPEATS) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_BURST} state_e;

  state_e             state;
  op_e                op_q;
  logic [WORD_W-1:0]  addr_q, data_q, pulses_q;
  logic [2:0]         sel_q;
  logic [IDX_W-1:0]   idx;
  logic [REP_W-1:0]   rep;
  step_t              cur;
  logic               burst_start, burst_done, eng_go, cpu_go;

  fps_step_table #(
    .IDX_W(IDX_W), .PROG_PULSES(PROG_PULSES), .FULL_PULSES(FULL_PULSES)
  ) u_table (
    .op(op_q), .idx(idx), .addr(addr_q), .data(data_q),
    .erase_sel(sel_q), .pulses(pulses_q), .step(cur)
  );

  fps_tclk_burst #(.CNT_W(WORD_W), .DIV_W(DIV_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(burst_start), .count(cur.data),
    .half(tclk_half), .tclk(tclk), .done(burst_done)
  );

  always_comb begin
    cmd_ready   = (state == S_IDLE);
    eng_valid   = (state == S_RUN) && (cur.act == ACT_MEMWR || cur.act == ACT_CTL);
    eng_ctl     = (cur.act == ACT_CTL);
    eng_addr    = cur.addr;
    eng_data    = cur.data;
    cpu_valid   = (state == S_RUN) && (cur.act == ACT_HALT || cur.act == ACT_RELEASE);
    cpu_release = (cur.act == ACT_RELEASE);
    burst_start = (state == S_RUN) && (cur.act == ACT_BURST);
    eng_go      = eng_valid && eng_ready;
    cpu_go      = cpu_valid && cpu_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      data_q   <= '0;
      pulses_q <= '0;
      sel_q    <= '0;
      idx      <= '0;
      rep      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q     <= op_e'(cmd_op);
            addr_q   <= cmd_addr;
            data_q   <= cmd_data;
            pulses_q <= cmd_pulses;
            sel_q    <= cmd_erase_sel;
            idx      <= '0;
            rep      <= '0;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          if (eng_go || cpu_go) begin
            idx <= idx + 1'b1;
          end else if (cur.act == ACT_BURST) begin
            state <= S_BURST;
          end else if (cur.act == ACT_END) begin
            if (op_q == OP_FULL && rep != REP_W'(REPEATS - 1)) begin
              rep <= rep + 1'b1;
              idx <= '0;
            end else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_BURST: begin
          if (burst_done) begin
            idx   <= idx + 1'b1;
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_checker.sv
module flash_prog_seq_checker #(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [DIV_W-1:0] tclk_half,
  input logic             eng_valid,
  input logic             eng_ready,
  input logic             eng_ctl,
  input logic [15:0]      eng_addr,
  input logic [15:0]      eng_data,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic             cpu_release,
  input logic             tclk,
  input logic             done
);
  logic [DIV_W:0] hi_run;
  logic [DIV_W:0] heff;

  always_comb heff = (tclk_half == '0) ? (DIV_W+1)'(1) : {1'b0, tclk_half};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= tclk ? hi_run + 1'b1 : '0;
  end

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_eng_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_addr) && $stable(eng_data) && $stable(eng_ctl)));

  assert_cpu_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_ready) |=> (cpu_valid && $stable(cpu_release)));

  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_valid && cpu_valid));

  assert_tclk_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tclk) |-> (hi_run == heff));

  assert_tclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tclk);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !eng_valid && !cpu_valid));
endmodule

bind flash_prog_seq flash_prog_seq_checker #(.DIV_W(DIV_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .tclk_half(tclk_half), .eng_valid(eng_valid), .eng_ready(eng_ready),
  .eng_ctl(eng_ctl), .eng_addr(eng_addr), .eng_data(eng_data),
  .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_release(cpu_release),
  .tclk(tclk), .done(done)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
  localparam int DIV_W = 10;
  localparam int FULLP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0, cmd_data = '0, cmd_pulses = '0;
  logic [2:0] cmd_erase_sel = '0;
  logic [DIV_W-1:0] tclk_half = '0;
  logic eng_valid, eng_ready, eng_ctl, cpu_valid, cpu_ready, cpu_release, tclk, done;
  logic [15:0] eng_addr, eng_data;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.DIV_W(DIV_W), .FULL_PULSES(FULLP)) u_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_erase_sel(cmd_erase_sel), .cmd_pulses(cmd_pulses), .tclk_half(tclk_half),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_ctl(eng_ctl),
    .eng_addr(eng_addr), .eng_data(eng_data), .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready), .cpu_release(cpu_release), .tclk(tclk), .done(done)
  );

  // log kinds: 0 halt, 1 release, 2 memory write, 3 control word, 4 pulse burst
  int exp_k[64], got_k[64];
  logic [15:0] exp_a[64], exp_d[64], got_a[64], got_d[64];
  int exp_n, got_n;
  int checks = 0, fails = 0;
  int cur_heff = 1;
  int period_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] code_of(input int sel);
    case (sel)
      1: return 16'hA504;
      2: return 16'hA506;
      3: return 16'hA50C;
      4: return 16'hA50E;
      default: return 16'hA502;
    endcase
  endfunction

  task automatic epush(input int k, input logic [15:0] a, input logic [15:0] d);
    exp_k[exp_n] = k; exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic erase_pass(input logic [15:0] code, input logic [15:0] a, input int n);
    epush(2, 16'h0128, code);
    epush(2, 16'h012A, 16'hA540);
    epush(2, 16'h012C, 16'hA500);
    epush(2, a, 16'h55AA);
    epush(3, 16'h0000, 16'h2409);
    if (n > 0) epush(4, 0, 16'(n));
    epush(2, 16'h0128, 16'hA500);
  endtask

  task automatic build(input int op, input logic [15:0] a, input logic [15:0] d,
                       input int sel, input int n);
    exp_n = 0;
    case (op)
      0: begin
        epush(0, 0, 0);
        epush(2, 16'h0128, 16'hA540);
        epush(2, 16'h012A, 16'hA540);
        epush(2, 16'h012C, 16'hA500);
        epush(2, a, d);
        epush(3, 16'h0000, 16'h2409);
        epush(4, 0, 16'd35);
        epush(2, 16'h0128, 16'hA500);
        epush(1, 0, 0);
      end
      1: erase_pass(code_of(sel), a, n);
      2: for (int i = 0; i < 3; i++) erase_pass(16'hA506, 16'hFFFE, FULLP);
      default: ;
    endcase
  endtask

  // responder and monitor
  logic pe_v = 0, pe_r = 0, pe_c = 0, pc_v = 0, pc_r = 0, pc_rel = 0, prev_t = 0;
  logic [15:0] pe_a = 0, pe_d = 0;
  int pend = 0, since_rise = 0, hi_cnt = 0;
  initial begin eng_ready = 0; cpu_ready = 0; end

  task automatic gpush(input int k, input logic [15:0] a, input logic [15:0] d);
    if (got_n < 64) begin got_k[got_n] = k; got_a[got_n] = a; got_d[got_n] = d; end
    got_n++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (tclk && !prev_t) begin
        if (pend > 0 && since_rise != 2*cur_heff) period_err++;
        pend++; since_rise = 0; hi_cnt = 0;
      end
      if (!tclk && prev_t && hi_cnt != cur_heff) period_err++;
      if (tclk) hi_cnt++;
      if ((pe_v && pe_r) || (pc_v && pc_r) || done) begin
        if (pend > 0) begin gpush(4, 0, 16'(pend)); pend = 0; end
      end
      if (pe_v && pe_r) gpush(pe_c ? 3 : 2, pe_a, pe_d);
      if (pc_v && pc_r) gpush(pc_rel ? 1 : 0, 0, 0);
    end
    prev_t = tclk;
    pe_v = eng_valid; pe_c = eng_ctl; pe_a = eng_addr; pe_d = eng_data;
    pc_v = cpu_valid; pc_rel = cpu_release;
    eng_ready = ($urandom % 3) != 0;
    cpu_ready = ($urandom % 2) != 0;
    pe_r = eng_ready; pc_r = cpu_ready;
  end

  task automatic run_cmd(input int op, input logic [15:0] a, input logic [15:0] d,
                         input int sel, input int n, input int half, input string req);
    int t;
    bit ok;
    tclk_half = DIV_W'(half);
    cur_heff = (half == 0) ? 1 : half;
    build(op, a, d, sel, n);
    got_n = 0; period_err = 0; pend = 0;
    @(negedge clk);
    cmd_op = 2'(op); cmd_addr = a; cmd_data = d; cmd_erase_sel = 3'(sel);
    cmd_pulses = 16'(n); cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    check(!cmd_ready, "R1", "ready after accept", cmd_ready, 0);
    cmd_addr = 16'h1357; cmd_data = 16'hBEEF; cmd_erase_sel = 3'd4; cmd_pulses = 16'd9;
    cmd_op = 2'd0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(t < 20000, req, "done timeout", t, 0);
    check(cmd_ready, "R9", "ready with done", cmd_ready, 1);
    @(negedge clk);
    check(!done, "R9", "done one cycle", done, 0);
    check(got_n == exp_n, req, "transaction count", got_n, exp_n);
    ok = 1;
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (ok && (got_k[i] != exp_k[i] || got_a[i] != exp_a[i] || got_d[i] != exp_d[i])) begin
        ok = 0;
        check(0, req, $sformatf("entry %0d kind/addr", i),
              {16'(got_k[i]), got_a[i], got_d[i]}, {16'(exp_k[i]), exp_a[i], exp_d[i]});
      end
    end
    if (ok) check(1, req, "sequence", 0, 0);
    check(period_err == 0, "R6", "pulse widths", period_err, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cmd_ready && !tclk && !done && !eng_valid && !cpu_valid, "R1", "reset state",
          {cmd_ready, tclk, done, eng_valid, cpu_valid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    run_cmd(0, 16'hF000, 16'h1234, 0, 0, 2, "R2");     // program
    run_cmd(0, 16'h0200, 16'hA5A5, 0, 0, 0, "R2");     // program, half 0 -> 1
    for (int s = 0; s < 8; s++)                        // R4 every select
      run_cmd(1, 16'hE000 + 16'(s), 16'h0, s, 2 + s % 3, 1 + s % 3, "R4");
    run_cmd(1, 16'hC000, 16'h0, 2, 0, 2, "R7");        // zero pulses
    run_cmd(2, 16'h0000, 16'h0, 0, 0, 1, "R5");        // full erase
    run_cmd(3, 16'h0000, 16'h0, 0, 0, 1, "R10");       // no-op
    for (int r = 0; r < 10; r++) begin                 // R3 random mix
      int op;
      op = $urandom % 4;
      run_cmd(op, 16'($urandom), 16'($urandom), $urandom % 8, $urandom % 7,
              $urandom % 4, op == 1 ? "R3" : "R8");
    end
    finish_run();
  end
endmodule